// File: doc/BRIEF.md
# Row-Burst Memory Access Scheduler

This block sits in front of the command stage of a multi-bank SDRAM controller. It accepts decoded read and write requests into an eight-entry queue. Each request carries a bank, a row, a column, a direction and a tag. The block picks one request per cycle to hand downstream. It keeps a record of the open row in every bank. It strings together requests that hit the open row of the bank it is working on, so that they form a burst. When a burst runs dry, it moves to a request for a different bank, which interleaves bank activity.

Reads normally go ahead of older writes. Writes that hit the open row of the active bank are tacked onto the end of its burst. When too many writes pile up, the scheduler switches to a write-drain mode with hysteresis. Requests to exactly the same location never overtake one another. Command timing, data movement and address decoding are handled elsewhere.

Top module: `burst_sched`

## Requirements
- R1: After synchronous reset the queue is empty, out_valid is 0, in_ready is 1, every bank's open row is unknown, and the pending-write count is 0.
- R2: Outside drain mode, once a request has issued, pending reads that target the same bank and the row it left open are issued next, oldest first, ahead of every other request.
- R3: Outside drain mode, a read may issue ahead of an older pending write to a different location.
- R4: When no row-hit read remains for the active bank, a pending write to that bank's open row is issued before any request to another bank.
- R5: Without a row-hit candidate, the oldest eligible read to a bank other than the active one goes next. Failing that, the oldest eligible write goes next, and failing that, the oldest eligible request of any kind. A request is eligible when R6 allows it to issue.
- R6: No request issues while an older pending request with identical bank, row and column (in_we 1 = write, 0 = read) is still queued.
- R7: When the number of pending writes reaches WR_THRESH (6), the scheduler enters drain mode. In drain mode a row-hit write to the active bank goes first, then the oldest write, then the normal order. Drain mode persists until the count falls below WR_THRESH-2 (4).
- R8: With 8 entries queued, in_ready is 0, and a request offered then is not accepted.
- R9: An entry is freed on the clock edge of its output handshake. Starting from a full queue, in_ready is 1 in the cycle after a handshake.
- R10: out_valid is 1 exactly when the queue holds at least one entry, and the out_* fields show the selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue can take a request |
| in_we | input | 1 | 1 = write, 0 = read |
| in_bank | input | 2 | Bank index |
| in_row | input | 8 | Row index |
| in_col | input | 6 | Column index |
| in_id | input | 4 | Request tag |
| out_valid | output | 1 | A selected request is presented |
| out_ready | input | 1 | Downstream takes the presented request |
| out_we | output | 1 | Direction of selected request |
| out_bank | output | 2 | Bank of selected request |
| out_row | output | 8 | Row of selected request |
| out_col | output | 6 | Column of selected request |
| out_id | output | 4 | Tag of selected request |

## Verification
A stale open-row entry or a wrong active bank breaks a burst at the output. The tag that comes out next is a request for another bank, so the error is visible on the very next handshake. A wrong pending-write count shows up differently. Writes start or stop leading the output order one or more handshakes early or late, which the bench catches by comparing full issue sequences. A lost or duplicated queue entry appears as a missing or repeated tag, or as out_valid still high once every expected tag has been issued.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 8;
  localparam int COL_W  = 6;
  localparam int ID_W   = 4;

  typedef struct packed {
    logic              we;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [ID_W-1:0]   id;
  } req_t;

  // identical location: ordering between these must be preserved
  function automatic logic same_loc(input req_t a, input req_t b);
    return (a.bank == b.bank) && (a.row == b.row) && (a.col == b.col);
  endfunction

  // write-drain hysteresis: enter at hi, stay while count >= lo
  function automatic logic drain_mode(input int cnt, input logic prev,
                                      input int hi, input int lo);
    return (cnt >= hi) || (prev && (cnt >= lo));
  endfunction
endpackage

// File: rtl/bs_queue.sv
module bs_queue
  import burst_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enq,
  input  req_t                  enq_req,
  input  logic                  deq,
  input  logic [IDX_W-1:0]      deq_idx,
  output req_t [DEPTH-1:0]      q,
  output logic [DEPTH-1:0]      vld,
  output logic [CNT_W-1:0]      occ
);
  req_t [DEPTH-1:0] sh_q, q_n;
  logic [DEPTH-1:0] sh_v, v_n;
  logic [CNT_W-1:0] tail;

  // close the gap left by a dequeued entry; index 0 stays the oldest
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    logic take_next;
    assign take_next = deq && (IDX_W'(i) >= deq_idx);
    if (i < DEPTH - 1) begin : g_mid
      assign sh_q[i] = take_next ? q[i+1] : q[i];
      assign sh_v[i] = take_next ? vld[i+1] : vld[i];
    end else begin : g_last
      assign sh_q[i] = take_next ? '0 : q[i];
      assign sh_v[i] = take_next ? 1'b0 : vld[i];
    end
  end

  always_comb begin
    q_n  = sh_q;
    v_n  = sh_v;
    tail = occ - CNT_W'(deq);
    if (enq) begin
      q_n[tail[IDX_W-1:0]] = enq_req;
      v_n[tail[IDX_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= '0;
      occ <= '0;
    end else begin
      q   <= q_n;
      vld <= v_n;
      occ <= occ + CNT_W'(enq) - CNT_W'(deq);
    end
  end
endmodule

// File: rtl/bs_openrow.sv
module bs_openrow
  import burst_sched_pkg::*;
#(
  parameter int NBANK = 1 << BANK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        upd,
  input  logic [BANK_W-1:0]           upd_bank,
  input  logic [ROW_W-1:0]            upd_row,
  output logic [NBANK-1:0][ROW_W-1:0] open_row,
  output logic [NBANK-1:0]            open_vld
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = upd && (upd_bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (rst) begin
        open_row[b] <= '0;
        open_vld[b] <= 1'b0;
      end else if (hit_bank) begin
        open_row[b] <= upd_row;
        open_vld[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bs_picker.sv
module bs_picker
  import burst_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NBANK = 1 << BANK_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NCLS = 5
) (
  input  req_t [DEPTH-1:0]            q,
  input  logic [DEPTH-1:0]            vld,
  input  logic [NBANK-1:0][ROW_W-1:0] open_row,
  input  logic [NBANK-1:0]            open_vld,
  input  logic [BANK_W-1:0]           cur_bank,
  input  logic                        cur_vld,
  input  logic                        drain,
  output logic [IDX_W-1:0]            sel_idx,
  output logic                        sel_any,
  output logic [DEPTH-1:0]            blocked
);
  logic [DEPTH-1:0] hit, in_cur, elig;
  logic [DEPTH-1:0] c_rh, c_wh, c_ro, c_w;
  logic [NCLS-1:0][DEPTH-1:0] order;

  function automatic logic [IDX_W:0] oldest(input logic [DEPTH-1:0] m);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (m[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      blocked[i] = 1'b0;
      for (int j = 0; j < i; j++)
        if (vld[j] && same_loc(q[j], q[i])) blocked[i] = 1'b1;
    end
    assign hit[i]    = open_vld[q[i].bank] && (open_row[q[i].bank] == q[i].row);
    assign in_cur[i] = cur_vld && (q[i].bank == cur_bank);
    assign elig[i]   = vld[i] && !blocked[i];
    assign c_rh[i]   = elig[i] && !q[i].we && hit[i] && in_cur[i];
    assign c_wh[i]   = elig[i] &&  q[i].we && hit[i] && in_cur[i];
    assign c_ro[i]   = elig[i] && !q[i].we && !in_cur[i];
    assign c_w[i]    = elig[i] &&  q[i].we;
  end

  always_comb begin
    if (drain) order = {elig, c_ro, c_rh, c_w, c_wh};
    else       order = {elig, c_w, c_ro, c_wh, c_rh};
    sel_idx = '0;
    sel_any = 1'b0;
    for (int c = NCLS - 1; c >= 0; c--) begin
      if (|order[c]) begin
        sel_idx = oldest(order[c])[IDX_W-1:0];
        sel_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WR_THRESH = 6,
  localparam int NBANK  = 1 << BANK_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int WR_LOW = WR_THRESH - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_we,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic [ID_W-1:0]   in_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_we,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic [ID_W-1:0]   out_id
);
  req_t [DEPTH-1:0]            q;
  logic [DEPTH-1:0]            vld;
  logic [CNT_W-1:0]            occ;
  logic [NBANK-1:0][ROW_W-1:0] open_row;
  logic [NBANK-1:0]            open_vld;
  logic [IDX_W-1:0]            sel_idx;
  logic                        sel_any;
  logic [DEPTH-1:0]            blocked;
  logic [BANK_W-1:0]           cur_bank;
  logic                        cur_vld;
  logic [CNT_W-1:0]            wr_cnt;
  logic                        drain_q;

  // named events for the checker
  logic enq, fire, drain, sel_blocked;
  req_t in_req, sel_req;

  assign in_req      = '{we: in_we, bank: in_bank, row: in_row, col: in_col, id: in_id};
  assign in_ready    = (occ != CNT_W'(DEPTH));
  assign enq         = in_valid && in_ready;
  assign sel_req     = q[sel_idx];
  assign out_valid   = sel_any;
  assign fire        = out_valid && out_ready;
  assign sel_blocked = blocked[sel_idx];
  assign drain       = drain_mode(int'(wr_cnt), drain_q, WR_THRESH, WR_LOW);

  assign out_we   = sel_req.we;
  assign out_bank = sel_req.bank;
  assign out_row  = sel_req.row;
  assign out_col  = sel_req.col;
  assign out_id   = sel_req.id;

  bs_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .enq(enq), .enq_req(in_req),
    .deq(fire), .deq_idx(sel_idx), .q(q), .vld(vld), .occ(occ)
  );

  bs_openrow #(.NBANK(NBANK)) u_openrow (
    .clk(clk), .rst(rst), .upd(fire), .upd_bank(out_bank), .upd_row(out_row),
    .open_row(open_row), .open_vld(open_vld)
  );

  bs_picker #(.DEPTH(DEPTH), .NBANK(NBANK)) u_picker (
    .q(q), .vld(vld), .open_row(open_row), .open_vld(open_vld),
    .cur_bank(cur_bank), .cur_vld(cur_vld), .drain(drain),
    .sel_idx(sel_idx), .sel_any(sel_any), .blocked(blocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_bank <= '0;
      cur_vld  <= 1'b0;
      wr_cnt   <= '0;
      drain_q  <= 1'b0;
    end else begin
      if (fire) begin
        cur_bank <= out_bank;
        cur_vld  <= 1'b1;
      end
      wr_cnt  <= wr_cnt + CNT_W'(enq && in_we) - CNT_W'(fire && out_we);
      drain_q <= drain;
    end
  end
endmodule

// File: rtl/bs_chk.sv
module bs_chk #(
  parameter int DEPTH     = 8,
  parameter int WR_THRESH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             in_valid,
  input logic             in_we,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_we,
  input logic [CNT_W-1:0] occ,
  input logic [CNT_W-1:0] wr_cnt,
  input logic             drain,
  input logic             sel_blocked
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CNT_W'(DEPTH)) |-> !in_ready);
  // R10
  valid_occ_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == (occ != '0));
  // R9
  free_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    ((occ == CNT_W'(DEPTH)) && out_valid && out_ready) |=> in_ready);
  // R7
  drain_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt >= CNT_W'(WR_THRESH)) |-> drain);
  // R7
  drain_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt < CNT_W'(WR_THRESH - 2)) |-> !drain);
  // R7
  wr_count_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_we && !(in_valid && in_ready && in_we))
    |=> (wr_cnt == $past(wr_cnt) - 1'b1));
  // R6
  same_loc_order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !sel_blocked);
endmodule

bind burst_sched bs_chk #(.DEPTH(DEPTH), .WR_THRESH(WR_THRESH)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .in_valid(in_valid), .in_we(in_we),
  .out_valid(out_valid), .out_ready(out_ready), .out_we(out_we),
  .occ(occ), .wr_cnt(wr_cnt), .drain(drain), .sel_blocked(sel_blocked)
);

// File: tb/burst_sched_bench.sv
module burst_sched_bench;
  import burst_sched_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_we = 1'b0;
  logic [BANK_W-1:0] in_bank = '0;
  logic [ROW_W-1:0]  in_row = '0;
  logic [COL_W-1:0]  in_col = '0;
  logic [ID_W-1:0]   in_id = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic              out_we;
  logic [BANK_W-1:0] out_bank;
  logic [ROW_W-1:0]  out_row;
  logic [COL_W-1:0]  out_col;
  logic [ID_W-1:0]   out_id;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  burst_sched u_burst_sched (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_we(in_we), .in_bank(in_bank), .in_row(in_row), .in_col(in_col), .in_id(in_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_we(out_we),
    .out_bank(out_bank), .out_row(out_row), .out_col(out_col), .out_id(out_id)
  );

  // vector = {we, bank, row, col, id}
  localparam int VW = 1 + BANK_W + ROW_W + COL_W + ID_W;
  localparam logic [VW-1:0] VEC [19] = '{
    // scenario 0: bursts, read preemption, write append, bank hop
    {1'b0, 2'd0, 8'd5, 6'd1, 4'd0}, {1'b1, 2'd1, 8'd3, 6'd0, 4'd1},
    {1'b0, 2'd1, 8'd7, 6'd2, 4'd2}, {1'b0, 2'd0, 8'd5, 6'd2, 4'd3},
    {1'b1, 2'd0, 8'd5, 6'd3, 4'd4}, {1'b0, 2'd2, 8'd1, 6'd0, 4'd5},
    {1'b0, 2'd0, 8'd9, 6'd0, 4'd6}, {1'b0, 2'd0, 8'd5, 6'd4, 4'd7},
    // scenario 1: same-location ordering
    {1'b1, 2'd0, 8'd2, 6'd5, 4'd0}, {1'b0, 2'd1, 8'd4, 6'd0, 4'd1},
    {1'b0, 2'd0, 8'd2, 6'd5, 4'd2},
    // scenario 2: write drain with hysteresis
    {1'b0, 2'd0, 8'd1, 6'd0, 4'd0}, {1'b1, 2'd1, 8'd2, 6'd0, 4'd1},
    {1'b1, 2'd1, 8'd2, 6'd1, 4'd2}, {1'b1, 2'd2, 8'd3, 6'd0, 4'd3},
    {1'b1, 2'd2, 8'd3, 6'd1, 4'd4}, {1'b1, 2'd3, 8'd4, 6'd0, 4'd5},
    {1'b1, 2'd3, 8'd4, 6'd1, 4'd6}, {1'b0, 2'd0, 8'd1, 6'd1, 4'd7}
  };
  localparam logic [ID_W-1:0] EXP [19] = '{
    4'd0, 4'd3, 4'd7, 4'd4, 4'd2, 4'd5, 4'd6, 4'd1,
    4'd1, 4'd0, 4'd2,
    4'd1, 4'd2, 4'd3, 4'd4, 4'd0, 4'd7, 4'd5, 4'd6
  };
  localparam int SC_BASE [3] = '{0, 8, 11};
  localparam int SC_N    [3] = '{8, 3, 8};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [VW-1:0] v);
    @(negedge clk);
    {in_we, in_bank, in_row, in_col, in_id} = v;
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    string tag;
    do_reset();
    @(negedge clk);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    check("R1 in_ready after reset", 32'(in_ready), 32'd1);

    for (int s = 0; s < 3; s++) begin
      case (s)
        0: tag = "R2/R3/R4/R5 issue order";
        1: tag = "R6 same-location order";
        default: tag = "R7 drain order";
      endcase
      do_reset();
      for (int k = 0; k < SC_N[s]; k++) push(VEC[SC_BASE[s] + k]);
      @(negedge clk);
      in_valid = 1'b0;
      if (SC_N[s] == 8) begin
        check("R8 in_ready at full", 32'(in_ready), 32'd0);
        // offer an extra request while full: must be dropped by the handshake
        {in_we, in_bank, in_row, in_col, in_id} = {1'b0, 2'd3, 8'd0, 6'd0, 4'd15};
        in_valid = 1'b1;
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
      end
      out_ready = 1'b1;
      for (int k = 0; k < SC_N[s]; k++) begin
        if (k > 0) @(negedge clk);
        if (k == 1 && SC_N[s] == 8)
          check("R9 in_ready after handshake from full", 32'(in_ready), 32'd1);
        check("R10 out_valid while queued", 32'(out_valid), 32'd1);
        check(tag, 32'(out_id), 32'(EXP[SC_BASE[s] + k]));
      end
      @(negedge clk);
      out_ready = 1'b0;
      check("R8/R10 queue empty after expected issues", 32'(out_valid), 32'd0);
    end

    // reset while holding entries clears the queue (R1)
    do_reset();
    push(VEC[0]);
    push(VEC[1]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 out_id with two queued", 32'(out_id), 32'd0);
    do_reset();
    @(negedge clk);
    check("R1 out_valid after mid-run reset", 32'(out_valid), 32'd0);
    check("R1 in_ready after mid-run reset", 32'(in_ready), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule